// File: doc/BRIEF.md
# Parity-Protected SPI Sensor Frame Engine

This block carries out every command exchange with an SPI accelerometer. A host presents one request at a time: a register write, a register read or an acceleration sample. The block builds the 16-bit command word with its write flag and odd-parity bit. It then runs a single chip-select window in which it shifts the two command bytes out and clocks two reply bytes back in. At the end it returns the result on `rsp` and pulses `done`.

The serial side uses SPI mode 0 with the most significant bit first. SCLK is produced from the system clock by a divider, so each SCLK half period lasts `CLK_DIV` system cycles. A register read or write returns the second reply byte. A sample request returns a 12-bit reading that is rebuilt from three separate bit groups of the reply. After each window, chip select stays high for a guard interval before the engine reports completion, so back-to-back requests always leave that gap on the wire.

Top module: `spi_frame_engine`

## Requirements
- R1: While `rst` is high, and right after it falls, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, `busy` is 0 and `done` is 0.
- R2: Opcode 2'b00 (write) sends first byte {p, 1, addr[5:0]} and then second byte `req_data`.
- R3: The parity bit p, at bit 7 of the first byte, makes the number of ones across all 16 command bits odd.
- R4: Opcode 2'b01 (read) sends first byte {p, 0, addr[5:0]} and then second byte 0x00.
- R5: An opcode with bit 1 set (2'b10 or 2'b11) is a sample request and sends 0x60 and then 0x0D, whatever the address and data inputs hold.
- R6: One request makes one chip-select-low window of exactly 32 SCLK rising edges. The 16 command bits go out first, and MOSI is 0 for the last 16 bits.
- R7: SPI mode 0 holds. SCLK is low whenever chip select is high, MISO is sampled on the rising edge, and MOSI does not change while SCLK is high.
- R8: For read and write requests, `rsp` is {4'b0, second reply byte}. The reply bytes are the MISO bits on rising edges 17..24 (first byte) and 25..32 (second byte), MSB first.
- R9: For sample requests, with reply bytes b0 and b1, `rsp` is {b0[1:0], b1[7:0], b0[7:6]}.
- R10: A request is taken only when `req_valid` is 1 and `busy` is 0. A request presented while `busy` is 1 is ignored. `done` is high for exactly one cycle, in which `busy` is 0, and chip select is low only while `busy` is 1.
- R11: Chip select stays high for at least 2·`GAP_SCLK`·`CLK_DIV` system cycles between two windows.
- R12: Every SCLK half period lasts `CLK_DIV` system cycles, so a window keeps chip select low for 64·`CLK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | 00 write, 01 read, 1x sample |
| req_addr | input | 6 | Register address |
| req_data | input | 8 | Write data |
| busy | output | 1 | Engine occupied, new requests ignored |
| done | output | 1 | One-cycle completion pulse |
| rsp | output | 12 | Register byte or 12-bit sample |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
The bench builds the engine with `CLK_DIV` = 2 and `GAP_SCLK` = 2. This keeps each exchange near 140 cycles, so all 64 addresses can be swept for writes with two data patterns each, and for reads and samples, within the cycle budget. A behavioural sensor model on the bench serves a distinct 16-bit reply to every request. This exercises every parity outcome, and it places both set and clear bits in each of the three scattered sample fields. Some requests have a rival request pulsed mid-window, and the next request is always issued in the cycle `done` rises, so the guard gap is measured at its minimum.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int ADDR_W     = 6;
  localparam int BYTE_W     = 8;
  localparam int CMD_W      = 2 * BYTE_W;
  localparam int FRAME_BITS = 2 * CMD_W;
  localparam int SAMPLE_W   = 12;

  localparam logic [1:0] OPC_WRITE = 2'b00;
  localparam logic [1:0] OPC_READ  = 2'b01;

  localparam logic [BYTE_W-1:0] SAMPLE_HDR = 8'h60;
  localparam logic [BYTE_W-1:0] SAMPLE_CTL = 8'h0D;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } eng_state_t;
endpackage

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(DIV - 1));
  assign tick = en && wrap;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/frame_encoder.sv
module frame_encoder
  import spi_frame_pkg::*;
(
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data,
  output logic [CMD_W-1:0]  cmd
);
  logic [BYTE_W-2:0] hdr;

  always_comb begin
    hdr = {1'b0, addr};
    cmd = '0;
    if (op[1]) begin
      cmd = {SAMPLE_HDR, SAMPLE_CTL};
    end else if (op == OPC_WRITE) begin
      hdr = {1'b1, addr};
      cmd = {~^{hdr, data}, hdr, data};
    end else begin
      hdr = {1'b0, addr};
      cmd = {~^hdr, hdr, {BYTE_W{1'b0}}};
    end
  end
endmodule

// File: rtl/reply_unpack.sv
module reply_unpack
  import spi_frame_pkg::*;
(
  input  logic                is_sample,
  input  logic [CMD_W-1:0]    rx,
  output logic [SAMPLE_W-1:0] value
);
  logic [BYTE_W-1:0] first_b;
  logic [BYTE_W-1:0] second_b;

  assign first_b  = rx[CMD_W-1:BYTE_W];
  assign second_b = rx[BYTE_W-1:0];

  always_comb begin
    if (is_sample) begin
      value = {first_b[1:0], second_b, first_b[7:6]};
    end else begin
      value = {{(SAMPLE_W-BYTE_W){1'b0}}, second_b};
    end
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_frame_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int GAP_SCLK = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BYTE_W-1:0]   req_data,
  output logic                busy,
  output logic                done,
  output logic [SAMPLE_W-1:0] rsp,
  output logic                spi_cs_n,
  output logic                spi_sclk,
  output logic                spi_mosi,
  input  logic                spi_miso
);
  localparam int BIT_W     = $clog2(FRAME_BITS);
  localparam int GAP_TICKS = 2 * GAP_SCLK;
  localparam int GAP_W     = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;

  eng_state_t               state_q;
  logic [FRAME_BITS-1:0]    tx_q;
  logic [CMD_W-1:0]         rx_q;
  logic [BIT_W-1:0]         bit_q;
  logic [GAP_W-1:0]         gap_q;
  logic                     sample_q;
  logic                     tick;
  logic [CMD_W-1:0]         cmd;
  logic [SAMPLE_W-1:0]      unpacked;

  sclk_divider #(.DIV(CLK_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (state_q != ST_IDLE),
    .tick (tick)
  );

  frame_encoder u_enc (
    .op   (req_op),
    .addr (req_addr),
    .data (req_data),
    .cmd  (cmd)
  );

  reply_unpack u_unp (
    .is_sample (sample_q),
    .rx        (rx_q),
    .value     (unpacked)
  );

  assign spi_mosi = tx_q[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      tx_q     <= '0;
      rx_q     <= '0;
      bit_q    <= '0;
      gap_q    <= '0;
      sample_q <= 1'b0;
      spi_cs_n <= 1'b1;
      spi_sclk <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rsp      <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            tx_q     <= {cmd, {CMD_W{1'b0}}};
            rx_q     <= '0;
            bit_q    <= '0;
            gap_q    <= '0;
            sample_q <= req_op[1];
            spi_cs_n <= 1'b0;
            busy     <= 1'b1;
            state_q  <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!spi_sclk) begin
              spi_sclk <= 1'b1;
              rx_q     <= {rx_q[CMD_W-2:0], spi_miso};
            end else begin
              spi_sclk <= 1'b0;
              tx_q     <= {tx_q[FRAME_BITS-2:0], 1'b0};
              if (bit_q == BIT_W'(FRAME_BITS - 1)) begin
                spi_cs_n <= 1'b1;
                state_q  <= ST_GAP;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_q == GAP_W'(GAP_TICKS - 1)) begin
              rsp     <= unpacked;
              done    <= 1'b1;
              busy    <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              gap_q <= gap_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_frame_engine_chk.sv
module spi_frame_engine_chk #(
  parameter int CLK_DIV  = 4,
  parameter int GAP_SCLK = 2
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi
);
  localparam int GAP_MIN = 2 * GAP_SCLK * CLK_DIV;

  logic [15:0] hi_cnt;
  logic [15:0] hold_cnt;
  logic        sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '1;
      hold_cnt <= '0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= spi_sclk;
      if (!spi_cs_n) begin
        hi_cnt <= '0;
      end else if (hi_cnt != 16'hFFFF) begin
        hi_cnt <= hi_cnt + 1'b1;
      end
      if (spi_sclk != sclk_d) begin
        hold_cnt <= '0;
      end else if (hold_cnt != 16'hFFFF) begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  AST_CS_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> busy); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk); // R7
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R7
  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (hi_cnt >= 16'(GAP_MIN))); // R11
  AST_SCLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (sclk_d && !spi_sclk) |-> (hold_cnt == 16'(CLK_DIV - 1))); // R12
endmodule

bind spi_frame_engine spi_frame_engine_chk #(
  .CLK_DIV  (CLK_DIV),
  .GAP_SCLK (GAP_SCLK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi)
);

// File: tb/spi_frame_engine_tb.sv
module spi_frame_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int GAPS       = 2;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [5:0]  req_addr = 6'd0;
  logic [7:0]  req_data = 8'd0;
  logic        busy, done, spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso;
  logic [11:0] rsp;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int sl_cnt   = 0;
  logic [31:0] cap = '0;
  logic [15:0] reply = '0;
  int low_run = 0, hi_run = 1000, last_low = 0, last_gap = 0;
  logic cs_prev = 1'b1;

  spi_frame_engine #(.CLK_DIV(DIV), .GAP_SCLK(GAPS)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .rsp(rsp), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // sensor model: count rising edges, capture MOSI, serve reply on MISO
  always @(posedge spi_sclk or negedge spi_cs_n) begin
    if (!spi_sclk) begin
      sl_cnt = 0;
      cap    = '0;
    end else begin
      cap    = {cap[30:0], spi_mosi};
      sl_cnt = sl_cnt + 1;
    end
  end

  always_comb begin
    if (sl_cnt >= 16 && sl_cnt < 32) spi_miso = reply[31 - sl_cnt];
    else spi_miso = 1'b0;
  end

  // chip-select window and gap measurement
  always @(negedge clk) begin
    cycles = cycles + 1;
    if (!spi_cs_n) begin
      if (cs_prev) last_gap = hi_run;
      low_run = low_run + 1;
      hi_run  = 0;
    end else begin
      if (!cs_prev) last_low = low_run;
      hi_run  = hi_run + 1;
      low_run = 0;
    end
    cs_prev = spi_cs_n;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic run_req(input logic [1:0] op, input logic [5:0] addr,
                         input logic [7:0] data, input logic [15:0] rep,
                         input bit poke, input bit first);
    logic [15:0] exp_cmd;
    logic [11:0] exp_rsp;
    logic        p;
    int          wait_n;
    if (op[1]) begin
      exp_cmd = 16'h600D;                                   // R5
      exp_rsp = {rep[9:8], rep[7:0], rep[15:14]};           // R9
    end else if (op == 2'b00) begin
      p = ($countones({1'b1, addr, data}) % 2) == 0;        // R3
      exp_cmd = {p, 1'b1, addr, data};                      // R2
      exp_rsp = {4'h0, rep[7:0]};                           // R8
    end else begin
      p = ($countones({1'b0, addr}) % 2) == 0;
      exp_cmd = {p, 1'b0, addr, 8'h00};                     // R4
      exp_rsp = {4'h0, rep[7:0]};
    end
    reply     = rep;
    req_op    = op;
    req_addr  = addr;
    req_data  = data;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      req_op = ~op; req_addr = ~addr; req_data = ~data; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    check(done == 1'b1, "R10 done seen", done, 1);
    check(busy == 1'b0, "R10 not busy at done", busy, 0);
    check(cap[31:16] == exp_cmd, op[1] ? "R5 command" : (op == 0 ? "R2 command" : "R4 command"),
          cap[31:16], exp_cmd);
    check($countones(cap[31:16]) % 2 == 1, "R3 odd parity", cap[31:16], exp_cmd);
    check(cap[15:0] == 16'h0 && sl_cnt == 32, "R6 frame length and zero tail",
          {cap[15:0], 16'(sl_cnt)}, 32'd32);
    check(rsp == exp_rsp, op[1] ? "R9 sample value" : "R8 register byte", rsp, exp_rsp);
    check(last_low == 64 * DIV, "R12 window length", last_low, 64 * DIV);
    if (!first)
      check(last_gap >= 2 * GAPS * DIV, "R11 cs gap", last_gap, 2 * GAPS * DIV);
    if (poke) begin
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0 && spi_cs_n == 1'b1,
            "R10 ignored request did not start", {done, busy, spi_cs_n}, 3'b001);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(spi_cs_n == 1 && spi_sclk == 0 && spi_mosi == 0 && busy == 0 && done == 0,
          "R1 reset state", {spi_cs_n, spi_sclk, spi_mosi, busy, done}, 5'b10000);
    rst = 1'b0;
    @(negedge clk);
    check(spi_cs_n == 1 && spi_sclk == 0 && busy == 0 && done == 0,
          "R1 after reset", {spi_cs_n, spi_sclk, busy, done}, 4'b1000);
    for (int a = 0; a < 64; a++) begin
      run_req(2'b00, 6'(a), 8'((a * 37 + 5) & 255), 16'(a * 1031 ^ 16'h5A3C),
              (a % 8) == 3, a == 0);
      run_req(2'b00, 6'(a), ~8'((a * 37 + 5) & 255), 16'(~(a * 517)), 1'b0, 1'b0);
    end
    for (int a = 0; a < 64; a++)
      run_req(2'b01, 6'(a), 8'(a * 11), 16'(a * 2053 ^ 16'hC3A5), (a % 8) == 5, 1'b0);
    for (int i = 0; i < 64; i++)
      run_req((i % 2) ? 2'b11 : 2'b10, 6'(i * 5), 8'(i * 29), 16'(i * 1031 ^ 16'hA5C3),
              (i % 16) == 7, 1'b0);
    run_req(2'b10, 6'h3F, 8'hFF, 16'hFFFF, 1'b0, 1'b0);
    run_req(2'b10, 6'h00, 8'h00, 16'h0000, 1'b0, 1'b0);
    run_req(2'b10, 6'h15, 8'h5A, 16'h3C00, 1'b0, 1'b0);
    run_req(2'b10, 6'h2A, 8'hA5, 16'hC300, 1'b0, 1'b0);
    finish_run();
  end

  initial begin
    wait (cycles >= WATCHDOG);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
    finish_run();
  end
endmodule